// File: doc/BRIEF.md
# Battery Measurement Scheduler with Charge Accumulator

This block decides which conversion a shared battery-monitor converter performs next. It runs from the slow time base and splits time into fixed measurement cycles of `CYCLE_CLKS` clocks. By default one cycle is 4 s at 32768 Hz. A voltage conversion opens every cycle. A temperature conversion follows it in one cycle out of every `TEMP_EVERY`. In mixed mode, the rest of each cycle is filled with back-to-back current conversions. In voltage-only mode, the converter stays idle between slots.

The converter is external and is driven by a start/kind/done/result handshake. The converter sets its own conversion length: 8192 clocks for voltage or temperature and 16384 clocks for current in the intended setup. Completed current results go into a saturating signed charge accumulator, and each one advances a conversion counter. The published current value is refreshed once per cycle, at the moment the voltage conversion starts. It takes the latest current result, which is the one nearest to that voltage conversion.

Top module: `batmon_sched`

## Requirements
- R1: After reset the effective mode is voltage-only (`mode_vonly_o`=1), no start is issued, and the voltage, temperature, current, charge and count outputs are all zero.
- R2: Cycle boundaries fall every `CYCLE_CLKS` clocks while running, and the first boundary comes on the first running clock. Each boundary queues one voltage conversion, kind code 1. A temperature conversion, kind code 2, is queued after the voltage conversion on the first boundary and on every `TEMP_EVERY`-th boundary after it.
- R3: `conv_start_o` is a one-clock pulse. No new start is issued while a conversion is outstanding, that is, until its `conv_done_i` has been seen.
- R4: In mixed mode, current conversions (kind code 0) are started back to back whenever no voltage or temperature conversion is pending. In voltage-only mode, no current conversion is ever started.
- R5: Each accepted current result, a `RES_W`-bit two's-complement value, is sign-extended and added to the `ACC_W`-bit charge accumulator. The same result increments the `CNT_W`-bit conversion counter, which wraps.
- R6: The charge accumulator saturates at its largest positive and most negative values and never wraps.
- R7: `cur_o` changes only when a voltage conversion starts. It then takes the most recent accepted current result, provided a new one has arrived since the previous voltage start.
- R8: An accepted voltage result appears on `volt_o`, and an accepted temperature result appears on `temp_o`, on the clock after `conv_done_i`.
- R9: While `run_i` is 0, no conversion starts and the cycle timer holds. The accumulator and counter are frozen, and a conversion outstanding at that time is discarded.
- R10: A one-clock `clr_cnt_i` pulse sets the conversion counter to 0 and leaves the charge unchanged. It overrides an increment in the same clock.
- R11: `mode_vonly_req_i` takes effect only at the next cycle boundary. A current conversion outstanding when the mode changes is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1 = measuring, 0 = standby with frozen state |
| mode_vonly_req_i | input | 1 | Requested mode: 1 = voltage-only, 0 = mixed |
| clr_cnt_i | input | 1 | One-clock command that clears the conversion counter |
| conv_start_o | output | 1 | Start pulse to the converter |
| conv_kind_o | output | 2 | Kind of conversion: 0 current, 1 voltage, 2 temperature |
| conv_done_i | input | 1 | Converter finished, result valid this clock |
| conv_result_i | input | RES_W | Conversion result, two's complement |
| mode_vonly_o | output | 1 | Effective mode |
| volt_o | output | RES_W | Latest voltage result |
| temp_o | output | RES_W | Latest temperature result |
| cur_o | output | RES_W | Published current, refreshed at each voltage start |
| charge_o | output | ACC_W | Saturating signed charge accumulator |
| conv_count_o | output | CNT_W | Number of accepted current conversions |

## Verification
The hardest case to reach is a current conversion that is still in flight when a mode change arrives, or when the run control drops. Its result must then vanish rather than be counted. The stimulus toggles the mode request right after a voltage start, so the switch lands while current conversions are running back to back. The run control is dropped in the middle of mixed operation. For each conversion, the bench's converter model records whether the run control fell during it, or whether the effective mode changed before its done. The scoreboard then expects either the accumulation or an unchanged charge and count. Large results of one sign drive the accumulator into both saturation limits within a few cycles.

// File: rtl/batmon_pkg.sv
package batmon_pkg;
    typedef enum logic [1:0] {
        KIND_CUR  = 2'd0,
        KIND_VOLT = 2'd1,
        KIND_TEMP = 2'd2
    } conv_kind_e;
endpackage

// File: rtl/batmon_cycle_timer.sv
module batmon_cycle_timer #(
    parameter int CYCLE_CLKS = 131072,
    parameter int TEMP_EVERY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic boundary_o,
    output logic temp_slot_o
);
    localparam int TW = (CYCLE_CLKS > 2) ? $clog2(CYCLE_CLKS) : 1;
    localparam int IW = (TEMP_EVERY > 2) ? $clog2(TEMP_EVERY) : 1;
    localparam logic [TW-1:0] LAST_T = TW'(CYCLE_CLKS - 1);
    localparam logic [IW-1:0] LAST_I = IW'(TEMP_EVERY - 1);

    typedef struct packed {
        logic [TW-1:0] tick;
        logic [IW-1:0] idx;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign boundary_o  = run_i && (tmr_q.tick == '0);
    assign temp_slot_o = (tmr_q.idx == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (run_i) begin
            tmr_d.tick = (tmr_q.tick == LAST_T) ? '0 : tmr_q.tick + 1'b1;
        end
        if (boundary_o) begin
            tmr_d.idx = (tmr_q.idx == LAST_I) ? '0 : tmr_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R2
    cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_o |=> !boundary_o);
    // R9
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(tmr_q));
endmodule

// File: rtl/batmon_charge_acc.sv
module batmon_charge_acc #(
    parameter int RES_W = 14,
    parameter int ACC_W = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [RES_W-1:0] sample_i,
    input  logic             clr_i,
    output logic [ACC_W-1:0] acc_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int SW = ACC_W + 1;
    localparam logic [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
    } acc_t;

    acc_t st_d, st_q;
    logic [SW-1:0] ext, sum;

    always_comb begin
        ext  = {{(SW-RES_W){sample_i[RES_W-1]}}, sample_i};
        sum  = {st_q.acc[ACC_W-1], st_q.acc} + ext;
        st_d = st_q;
        if (en_i) begin
            if (sum[SW-1] != sum[SW-2]) st_d.acc = sum[SW-1] ? NEG_LIM : POS_LIM;
            else                        st_d.acc = sum[ACC_W-1:0];
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (clr_i) st_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o = st_q.acc;
    assign cnt_o = st_q.cnt;

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> ($stable(acc_o) && $stable(cnt_o)));
    // R10
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));
    // R6
    no_pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !sample_i[RES_W-1] && !acc_o[ACC_W-1]) |=> !acc_o[ACC_W-1]);
    // R6
    no_neg_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && sample_i[RES_W-1] && acc_o[ACC_W-1]) |=> acc_o[ACC_W-1]);
endmodule

// File: rtl/batmon_sched.sv
module batmon_sched
    import batmon_pkg::*;
#(
    parameter int CYCLE_CLKS = 131072,
    parameter int TEMP_EVERY = 4,
    parameter int RES_W      = 14,
    parameter int ACC_W      = 32,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             mode_vonly_req_i,
    input  logic             clr_cnt_i,
    output logic             conv_start_o,
    output logic [1:0]       conv_kind_o,
    input  logic             conv_done_i,
    input  logic [RES_W-1:0] conv_result_i,
    output logic             mode_vonly_o,
    output logic [RES_W-1:0] volt_o,
    output logic [RES_W-1:0] temp_o,
    output logic [RES_W-1:0] cur_o,
    output logic [ACC_W-1:0] charge_o,
    output logic [CNT_W-1:0] conv_count_o
);
    typedef struct packed {
        logic             busy;
        logic             drop;
        conv_kind_e       kind;
        logic             start;
        logic             pend_v;
        logic             pend_t;
        logic             mode_vonly;
        logic             have_cur;
        logic [RES_W-1:0] last_cur;
        logic [RES_W-1:0] cur;
        logic [RES_W-1:0] volt;
        logic [RES_W-1:0] temp;
    } seq_t;

    localparam seq_t SEQ_RST = '{mode_vonly: 1'b1, kind: KIND_CUR, default: '0};

    seq_t sq_d, sq_q;
    logic boundary, temp_slot, acc_en;

    batmon_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS), .TEMP_EVERY(TEMP_EVERY)) tmr_i (
        .clk(clk), .rst_n(rst_n), .run_i(run_i),
        .boundary_o(boundary), .temp_slot_o(temp_slot)
    );

    always_comb begin
        sq_d       = sq_q;
        sq_d.start = 1'b0;
        acc_en     = 1'b0;
        if (sq_q.busy && conv_done_i) begin
            sq_d.busy = 1'b0;
            sq_d.drop = 1'b0;
            if (!sq_q.drop && run_i) begin
                unique case (sq_q.kind)
                    KIND_CUR: begin
                        acc_en        = 1'b1;
                        sq_d.last_cur = conv_result_i;
                        sq_d.have_cur = 1'b1;
                    end
                    KIND_VOLT: sq_d.volt = conv_result_i;
                    default:   sq_d.temp = conv_result_i;
                endcase
            end
        end else if (sq_q.busy && !run_i) begin
            sq_d.drop = 1'b1;
        end
        if (boundary) begin
            sq_d.pend_v     = 1'b1;
            sq_d.pend_t     = sq_q.pend_t | temp_slot;
            sq_d.mode_vonly = mode_vonly_req_i;
            if (sq_q.busy && !conv_done_i && sq_q.kind == KIND_CUR &&
                mode_vonly_req_i != sq_q.mode_vonly) begin
                sq_d.drop = 1'b1;
            end
        end else if (run_i && !sq_q.busy) begin
            if (sq_q.pend_v) begin
                sq_d.start  = 1'b1;
                sq_d.busy   = 1'b1;
                sq_d.kind   = KIND_VOLT;
                sq_d.pend_v = 1'b0;
                if (sq_q.have_cur) begin
                    sq_d.cur      = sq_q.last_cur;
                    sq_d.have_cur = 1'b0;
                end
            end else if (sq_q.pend_t) begin
                sq_d.start  = 1'b1;
                sq_d.busy   = 1'b1;
                sq_d.kind   = KIND_TEMP;
                sq_d.pend_t = 1'b0;
            end else if (!sq_q.mode_vonly) begin
                sq_d.start = 1'b1;
                sq_d.busy  = 1'b1;
                sq_d.kind  = KIND_CUR;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= SEQ_RST;
        else        sq_q <= sq_d;
    end

    batmon_charge_acc #(.RES_W(RES_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) acc_i (
        .clk(clk), .rst_n(rst_n), .en_i(acc_en), .sample_i(conv_result_i),
        .clr_i(clr_cnt_i), .acc_o(charge_o), .cnt_o(conv_count_o)
    );

    assign conv_start_o = sq_q.start;
    assign conv_kind_o  = sq_q.kind;
    assign mode_vonly_o = sq_q.mode_vonly;
    assign volt_o       = sq_q.volt;
    assign temp_o       = sq_q.temp;
    assign cur_o        = sq_q.cur;

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);
    // R9
    halt_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !conv_start_o);
    // R11
    mode_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(mode_vonly_o));
    // R4
    vonly_no_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start_o && mode_vonly_o) |-> (conv_kind_o != KIND_CUR));
    // R7
    cur_at_volt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_start_o && conv_kind_o == KIND_VOLT) |=>
            (!(conv_start_o && conv_kind_o == KIND_VOLT) -> $stable(cur_o)));
endmodule

// File: tb/batmon_sched_tb.sv
module batmon_sched_tb_top;
    localparam int CYC   = 200;
    localparam int TEV   = 4;
    localparam int RES_W = 14;
    localparam int ACC_W = 16;
    localparam int CNT_W = 16;
    localparam int LAT_VT = 8;
    localparam int LAT_C  = 16;
    localparam longint POS_LIM = (64'sd1 <<< (ACC_W-1)) - 1;
    localparam longint NEG_LIM = -(64'sd1 <<< (ACC_W-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0, mode_req = 1'b1, clr_cnt = 1'b0;
    logic conv_start, conv_done = 1'b0;
    logic [1:0] conv_kind;
    logic [RES_W-1:0] conv_result = '0;
    logic mode_vonly;
    logic [RES_W-1:0] volt, temp, cur;
    logic [ACC_W-1:0] charge;
    logic [CNT_W-1:0] count;

    always #5 clk = ~clk;

    batmon_sched #(.CYCLE_CLKS(CYC), .TEMP_EVERY(TEV), .RES_W(RES_W),
                   .ACC_W(ACC_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_i(run), .mode_vonly_req_i(mode_req),
        .clr_cnt_i(clr_cnt), .conv_start_o(conv_start), .conv_kind_o(conv_kind),
        .conv_done_i(conv_done), .conv_result_i(conv_result),
        .mode_vonly_o(mode_vonly), .volt_o(volt), .temp_o(temp), .cur_o(cur),
        .charge_o(charge), .conv_count_o(count)
    );

    int errors = 0, checks = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    typedef struct {
        logic [1:0]              kind;
        logic signed [RES_W-1:0] res;
        bit                      drop;
    } item_t;
    item_t sbq[$];

    logic signed [RES_W-1:0] cur_val = 14'sd0;
    int vt_seq = 100;
    longint exp_charge = 0;
    int exp_cnt = 0;
    logic signed [RES_W-1:0] last_cur = '0;
    bit have_cur = 1'b0;
    int n_v = 0, n_t = 0, n_c = 0;

    // Converter model (driver): pushes expected items
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start) begin
                automatic item_t it;
                automatic int lat;
                automatic logic m0 = mode_vonly;
                it.kind = conv_kind;
                it.drop = 1'b0;
                if (conv_kind == 2'd0) begin
                    it.res = cur_val;
                    lat = LAT_C;
                end else begin
                    it.res = RES_W'(vt_seq);
                    vt_seq++;
                    lat = LAT_VT;
                end
                for (int i = 1; i < lat; i++) begin
                    @(posedge clk);
                    if (!run) it.drop = 1'b1;
                    @(negedge clk);
                    // R3: no new start while this conversion is outstanding
                    if (conv_start) chk(1'b0, "R3", "start while busy", 1, 0);
                end
                if (mode_vonly != m0) it.drop = 1'b1;
                conv_done   = 1'b1;
                conv_result = it.res;
                @(posedge clk);
                if (!run) it.drop = 1'b1;
                sbq.push_back(it);
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
    end

    // Monitor: pops expected items and compares outputs
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0) begin
                automatic item_t it = sbq.pop_front();
                if (it.kind == 2'd0) begin
                    if (!it.drop) begin
                        exp_charge = exp_charge + it.res;
                        if (exp_charge > POS_LIM) exp_charge = POS_LIM;
                        if (exp_charge < NEG_LIM) exp_charge = NEG_LIM;
                        exp_cnt = (exp_cnt + 1) & 16'hFFFF;
                        last_cur = it.res;
                        have_cur = 1'b1;
                    end
                    // R5 accumulate and count (R6 saturation bounds applied)
                    chk($signed(charge) == exp_charge, "R5", "charge",
                        $signed(charge), exp_charge);
                    chk(int'(count) == exp_cnt, "R5", "count", count, exp_cnt);
                end else if (it.kind == 2'd1) begin
                    if (!it.drop)
                        chk($signed(volt) == it.res, "R8", "volt", $signed(volt), it.res);
                end else begin
                    if (!it.drop)
                        chk($signed(temp) == it.res, "R8", "temp", $signed(temp), it.res);
                end
            end
        end
    end

    // Start monitor: counts kinds and checks the published current
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start) begin
                case (conv_kind)
                    2'd0: n_c++;
                    2'd1: begin
                        n_v++;
                        if (have_cur) begin
                            chk($signed(cur) == last_cur, "R7", "cur at volt start",
                                $signed(cur), last_cur);
                            have_cur = 1'b0;
                        end
                    end
                    default: n_t++;
                endcase
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        automatic longint snap_c;
        automatic int snap_n;
        cycles(3);
        // R1 reset state
        chk(mode_vonly == 1'b1, "R1", "mode", mode_vonly, 1);
        chk(conv_start == 1'b0, "R1", "start", conv_start, 0);
        chk(charge == '0 && count == '0, "R1", "charge/count", charge, 0);
        chk(volt == '0 && temp == '0 && cur == '0, "R1", "results", cur, 0);
        rst_n = 1'b1;
        cycles(2);

        // Voltage-only schedule
        n_v = 0; n_t = 0; n_c = 0;
        run = 1'b1;
        cycles(4*CYC - 100);
        chk(n_v == 4, "R2", "voltage slots in 4 cycles", n_v, 4);
        chk(n_t == 1, "R2", "temperature slots in 4 cycles", n_t, 1);
        chk(n_c == 0, "R4", "current starts in voltage-only", n_c, 0);

        // Mode change request right after a voltage start
        do @(negedge clk); while (!(conv_start && conv_kind == 2'd1));
        mode_req = 1'b0;
        cur_val = 14'sd8000;
        cycles(50);
        chk(mode_vonly == 1'b1, "R11", "mode before boundary", mode_vonly, 1);
        cycles(CYC);
        chk(mode_vonly == 1'b0, "R11", "mode after boundary", mode_vonly, 0);
        n_c = 0;
        cycles(2*CYC);
        chk(n_c >= 10, "R4", "mixed current starts", n_c, 10);
        cycles(2*CYC);
        chk($signed(charge) == POS_LIM, "R6", "positive limit", $signed(charge), POS_LIM);
        chk($signed(cur) == 8000, "R7", "published current", $signed(cur), 8000);

        cur_val = -14'sd8000;
        cycles(6*CYC);
        chk($signed(charge) == NEG_LIM, "R6", "negative limit", $signed(charge), NEG_LIM);

        // Standby mid-conversion
        run = 1'b0;
        cycles(100);
        snap_c = $signed(charge);
        snap_n = count;
        n_v = 0; n_t = 0; n_c = 0;
        cycles(300);
        chk(n_v + n_t + n_c == 0, "R9", "starts in standby", n_v + n_t + n_c, 0);
        chk($signed(charge) == snap_c, "R9", "charge frozen", $signed(charge), snap_c);
        chk(int'(count) == snap_n, "R9", "count frozen", count, snap_n);
        chk(snap_n != 0, "R10", "count nonzero before clear", snap_n, 1);
        clr_cnt = 1'b1;
        @(negedge clk);
        clr_cnt = 1'b0;
        exp_cnt = 0;
        chk(count == '0, "R10", "count cleared", count, 0);
        chk($signed(charge) == snap_c, "R10", "charge kept", $signed(charge), snap_c);

        // Back to voltage-only while running
        mode_req = 1'b1;
        run = 1'b1;
        cycles(CYC + 20);
        n_c = 0; n_v = 0;
        cycles(2*CYC);
        chk(mode_vonly == 1'b1, "R11", "mode back to voltage-only", mode_vonly, 1);
        chk(n_c == 0, "R4", "no current after switch", n_c, 0);
        chk(n_v == 2, "R2", "voltage slots in 2 cycles", n_v, 2);
        cycles(20);
        finish_run();
    end
endmodule